// File: doc/BRIEF.md
# Store Commit Queue

This block holds the stores of an out-of-order core between dispatch and the data cache. Stores enter at the tail in program order and get a slot index back. Execute fills in a slot's address, data and size later. A commit bound, given as a sequence number, makes older stores eligible to write. A separate writeback pointer then sends eligible stores to the cache one at a time and in order. A store that the cache refuses is parked until the cache signals a retry.

Stores of size zero and prefetch entries finish without any cache write. The cache reports completion of real writes by slot index, and these reports may come out of order. Slots are freed from the head only when a run of completed stores starts at the head, and the whole run is freed in one step. A squash removes the youngest stores that have not been committed yet.

The queue also reports how many new memory operations the core may dispatch. This is the smaller of the load queue's free count and its own free count.

Top module: `sq_store_queue`

## Requirements
- R1: The queue holds at most DEPTH stores. `full_o` is high when DEPTH stores are held. An allocation while full is ignored: `alloc_idx_o` and `sq_count_o` do not change. Each accepted allocation returns the current `alloc_idx_o` as the store's slot, and the slot index advances by one modulo DEPTH+1.
- R2: A commit walks from the oldest store and marks each unmarked store eligible. It stops at the first unmarked store whose sequence number is greater (unsigned) than `commit_seq_i`. Stores beyond that point are not written.
- R3: Eligible stores that have been executed are written strictly oldest first. Each write shows the address, data and size given at execute and the store's slot on `wr_idx_o`. A write is taken when `wr_valid_o` and `wr_ready_i` are both high at a clock edge.
- R4: An eligible store executed with size 0 completes without any cache write.
- R5: An eligible store executed with the prefetch flag set completes without any cache write.
- R6: If `wr_ready_i` is low while `wr_valid_o` is high, `wr_valid_o` drops on the next cycle and `blocked_o` rises. No request is made until `wr_retry_i` is seen. The cycle after the retry, the same request is presented again.
- R7: `done_i` with `done_idx_i` marks a written store complete. Storage is freed only from the head. A completed store behind an incomplete older one stays counted. When the head store completes, the whole run of consecutive completed stores is freed in one step, two cycles after the `done_i` edge.
- R8: A squash removes, from the youngest back, each uncommitted store with a sequence number greater than `squash_seq_i`. It stops at the first committed or older store, and the next allocation reuses the first freed slot. In a squash cycle, allocation and commit are ignored.
- R9: One cycle after each clock edge, `free_o` equals the smaller of `lq_free_i` (as sampled at that edge) and DEPTH minus the number of stores held after that edge.
- R10: After reset the queue is empty: `sq_count_o`=0, `full_o`=0, `alloc_idx_o`=0, `wr_valid_o`=0, `blocked_o`=0 and `free_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_i | input | 1 | Allocate a slot for a new store |
| alloc_seq_i | input | SEQ_W | Sequence number of the new store |
| alloc_idx_o | output | IDX_W | Slot that the next allocation receives |
| full_o | output | 1 | DEPTH stores held |
| exec_i | input | 1 | Execute result for a slot |
| exec_idx_i | input | IDX_W | Slot being executed |
| exec_addr_i | input | ADDR_W | Store address |
| exec_data_i | input | DATA_W | Store data |
| exec_size_i | input | SIZE_W | Store size in bytes, 0 means nothing to write |
| exec_pf_i | input | 1 | Entry is a data prefetch |
| commit_i | input | 1 | Commit bound valid |
| commit_seq_i | input | SEQ_W | Youngest committed sequence number |
| squash_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Stores younger than this are removed |
| wr_valid_o | output | 1 | Cache write request |
| wr_ready_i | input | 1 | Cache takes the write |
| wr_retry_i | input | 1 | Cache can take a refused write again |
| wr_idx_o | output | IDX_W | Slot of the write |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| wr_size_o | output | SIZE_W | Write size |
| done_i | input | 1 | A write has completed |
| done_idx_i | input | IDX_W | Slot of the completed write |
| lq_free_i | input | LQF_W | Free load queue entries |
| free_o | output | CNT_W | Memory operations that may still be dispatched |
| sq_count_o | output | CNT_W | Stores held |
| blocked_o | output | 1 | A refused write is waiting for retry |

## Verification
A corrupted writeback pointer or eligibility flag shows up within a few cycles of a commit. The write that appears on the cache port is the wrong one, or an expected write never comes, so every expected write is matched against its address and data. A wrong head or drain count shows in `sq_count_o` and `free_o` two cycles after a completion. A squash that cuts too far or too short shows in `alloc_idx_o` on the very next cycle. A wrong blocked state shows as a request that appears without a retry, or one that never comes back after the retry.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    WB_IDLE = 2'd0,
    WB_SEND = 2'd1,
    WB_HOLD = 2'd2
  } wb_state_e;
endpackage

// File: rtl/sq_payload_ram.sv
module sq_payload_ram #(
  parameter int N  = 9,
  parameter int AW = 4,
  parameter int W  = 52
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sq_scan.sv
module sq_scan #(
  parameter int DEPTH = 8,
  parameter int ARR   = DEPTH + 1,
  parameter int IDX_W = 4,
  parameter int CNT_W = 4,
  parameter int SEQ_W = 8
) (
  input  logic [IDX_W-1:0]            head,
  input  logic [IDX_W-1:0]            tail,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [ARR-1:0]              elig,
  input  logic [ARR-1:0]              dn,
  input  logic [ARR-1:0][SEQ_W-1:0]   seq,
  input  logic [SEQ_W-1:0]            commit_bound,
  input  logic [SEQ_W-1:0]            squash_bound,
  output logic [ARR-1:0]              mark,
  output logic [CNT_W-1:0]            mark_cnt,
  output logic [IDX_W-1:0]            new_tail,
  output logic [IDX_W-1:0]            new_head
);
  function automatic logic [IDX_W-1:0] wrap(input logic [IDX_W-1:0] b, input int off);
    int s;
    s = int'(b) + off;
    if (s >= ARR) s = s - ARR;
    if (s < 0) s = s + ARR;
    return IDX_W'(s);
  endfunction

  // commit walk, oldest first
  always_comb begin
    logic go;
    logic [IDX_W-1:0] p;
    mark = '0;
    mark_cnt = '0;
    go = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      p = wrap(head, k);
      if (go && k < int'(cnt) && !elig[p]) begin
        if (seq[p] > commit_bound) go = 1'b0;
        else begin
          mark[p] = 1'b1;
          mark_cnt = mark_cnt + CNT_W'(1);
        end
      end
    end
  end

  // squash walk, youngest first
  always_comb begin
    logic go;
    logic [IDX_W-1:0] p;
    new_tail = tail;
    go = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      p = wrap(tail, -1 - k);
      if (go && k < int'(cnt)) begin
        if (!elig[p] && seq[p] > squash_bound) new_tail = p;
        else go = 1'b0;
      end
    end
  end

  // head drain over consecutive completed entries
  always_comb begin
    logic go;
    logic [IDX_W-1:0] p;
    new_head = head;
    go = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      p = wrap(head, k);
      if (go && k < int'(cnt) && dn[p]) new_head = wrap(head, k + 1);
      else go = 1'b0;
    end
  end
endmodule

// File: rtl/sq_wb_fsm.sv
module sq_wb_fsm
  import sq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic can_go,
  input  logic no_write,
  input  logic wr_ready,
  input  logic retry,
  output logic skip_fire,
  output logic accept_fire,
  output logic wr_valid,
  output logic blocked
);
  wb_state_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    skip_fire = 1'b0;
    accept_fire = 1'b0;
    case (st_q)
      WB_IDLE: if (can_go) begin
        if (no_write) skip_fire = 1'b1;
        else st_n = WB_SEND;
      end
      WB_SEND: if (wr_ready) begin
        accept_fire = 1'b1;
        st_n = WB_IDLE;
      end else st_n = WB_HOLD;
      WB_HOLD: if (retry) st_n = WB_SEND;
      default: st_n = WB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= WB_IDLE;
    else st_q <= st_n;
  end

  assign wr_valid = (st_q == WB_SEND);
  assign blocked  = (st_q == WB_HOLD);
endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  parameter int LQF_W  = 8,
  localparam int ARR   = DEPTH + 1,
  localparam int IDX_W = $clog2(ARR),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PW    = ADDR_W + DATA_W + SIZE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_i,
  input  logic [SEQ_W-1:0]  alloc_seq_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  output logic              full_o,
  input  logic              exec_i,
  input  logic [IDX_W-1:0]  exec_idx_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic [DATA_W-1:0] exec_data_i,
  input  logic [SIZE_W-1:0] exec_size_i,
  input  logic              exec_pf_i,
  input  logic              commit_i,
  input  logic [SEQ_W-1:0]  commit_seq_i,
  input  logic              squash_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  input  logic              wr_retry_i,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [SIZE_W-1:0] wr_size_o,
  input  logic              done_i,
  input  logic [IDX_W-1:0]  done_idx_i,
  input  logic [LQF_W-1:0]  lq_free_i,
  output logic [CNT_W-1:0]  free_o,
  output logic [CNT_W-1:0]  sq_count_o,
  output logic              blocked_o
);
  function automatic logic [IDX_W-1:0] step1(input logic [IDX_W-1:0] b);
    return (int'(b) == ARR - 1) ? '0 : b + IDX_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] occ(input logic [IDX_W-1:0] h, input logic [IDX_W-1:0] t);
    int d;
    d = int'(t) - int'(h);
    if (d < 0) d = d + ARR;
    return CNT_W'(d);
  endfunction

  logic [IDX_W-1:0] head_q, tail_q, wbp_q;
  logic [IDX_W-1:0] head_n, tail_n;
  logic [CNT_W-1:0] pend_q, cnt, cnt_n;
  logic [ARR-1:0]   exe_q, elg_q, dn_q, zr_q, pf_q;
  logic [ARR-1:0][SEQ_W-1:0] seq_q;

  logic [ARR-1:0]   mark;
  logic [CNT_W-1:0] mark_cnt;
  logic [IDX_W-1:0] sq_tail, drn_head;
  logic             alloc_ok, commit_ok, exec_ok;
  logic             can_go, skip_fire, accept_fire;
  logic [PW-1:0]    rdata;

  assign cnt       = occ(head_q, tail_q);
  assign full_o    = (int'(cnt) == DEPTH);
  assign alloc_ok  = alloc_i && !squash_i && !full_o;
  assign commit_ok = commit_i && !squash_i;
  assign exec_ok   = exec_i && !exe_q[exec_idx_i];

  sq_scan #(
    .DEPTH(DEPTH), .ARR(ARR), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)
  ) u_scan (
    .head(head_q), .tail(tail_q), .cnt(cnt),
    .elig(elg_q), .dn(dn_q), .seq(seq_q),
    .commit_bound(commit_seq_i), .squash_bound(squash_seq_i),
    .mark(mark), .mark_cnt(mark_cnt),
    .new_tail(sq_tail), .new_head(drn_head)
  );

  assign can_go = (pend_q != '0) && (wbp_q != tail_q) && elg_q[wbp_q] && exe_q[wbp_q];

  sq_wb_fsm u_fsm (
    .clk(clk), .rst(rst),
    .can_go(can_go), .no_write(zr_q[wbp_q] || pf_q[wbp_q]),
    .wr_ready(wr_ready_i), .retry(wr_retry_i),
    .skip_fire(skip_fire), .accept_fire(accept_fire),
    .wr_valid(wr_valid_o), .blocked(blocked_o)
  );

  sq_payload_ram #(.N(ARR), .AW(IDX_W), .W(PW)) u_ram (
    .clk(clk), .we(exec_ok), .waddr(exec_idx_i),
    .wdata({exec_addr_i, exec_data_i, exec_size_i}),
    .raddr(wbp_q), .rdata(rdata)
  );

  assign {wr_addr_o, wr_data_o, wr_size_o} = rdata;
  assign wr_idx_o    = wbp_q;
  assign alloc_idx_o = tail_q;
  assign sq_count_o  = cnt;

  assign head_n = drn_head;
  always_comb begin
    tail_n = tail_q;
    if (squash_i) tail_n = sq_tail;
    else if (alloc_ok) tail_n = step1(tail_q);
  end
  assign cnt_n = occ(head_n, tail_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      wbp_q  <= '0;
      pend_q <= '0;
      free_o <= '0;
      exe_q  <= '0;
      elg_q  <= '0;
      dn_q   <= '0;
      zr_q   <= '0;
      pf_q   <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      if (skip_fire || accept_fire) wbp_q <= step1(wbp_q);
      pend_q <= pend_q + (commit_ok ? mark_cnt : '0)
                - CNT_W'(skip_fire) - CNT_W'(done_i);
      if (int'(lq_free_i) < DEPTH - int'(cnt_n)) free_o <= CNT_W'(lq_free_i);
      else free_o <= CNT_W'(DEPTH) - cnt_n;
      if (commit_ok) elg_q <= elg_q | mark;
      if (exec_ok) begin
        exe_q[exec_idx_i] <= 1'b1;
        zr_q[exec_idx_i]  <= (exec_size_i == '0);
        pf_q[exec_idx_i]  <= exec_pf_i;
      end
      if (skip_fire) dn_q[wbp_q] <= 1'b1;
      if (done_i) dn_q[done_idx_i] <= 1'b1;
      if (alloc_ok) begin
        exe_q[tail_q] <= 1'b0;
        elg_q[tail_q] <= 1'b0;
        dn_q[tail_q]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_ok) seq_q[tail_q] <= alloc_seq_i;
  end
endmodule

// File: rtl/sq_store_queue_chk.sv
module sq_store_queue_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 4,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_i,
  input logic             squash_i,
  input logic             full_o,
  input logic [IDX_W-1:0] alloc_idx_o,
  input logic [CNT_W-1:0] sq_count_o,
  input logic [CNT_W-1:0] pend_q,
  input logic             wr_valid_o,
  input logic             wr_ready_i,
  input logic             wr_retry_i,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic             blocked_o,
  input logic [CNT_W-1:0] free_o
);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    int'(sq_count_o) <= DEPTH);

  assert_full_alloc_dropped_R1: assert property (@(posedge clk) disable iff (rst)
    alloc_i && full_o && !squash_i |=> $stable(alloc_idx_o));

  // R2: eligible stores still waiting never outnumber stores held
  assert_pending_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    pend_q <= sq_count_o);

  assert_refusal_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o && !wr_ready_i |=> !wr_valid_o && blocked_o);

  assert_held_slot_stable_R6: assert property (@(posedge clk) disable iff (rst)
    blocked_o |=> $stable(wr_idx_o));

  assert_wait_for_retry_R6: assert property (@(posedge clk) disable iff (rst)
    blocked_o && !wr_retry_i |=> blocked_o && !wr_valid_o);

  assert_free_bound_R9: assert property (@(posedge clk) disable iff (rst)
    int'(free_o) <= DEPTH);
endmodule

bind sq_store_queue sq_store_queue_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .alloc_i(alloc_i), .squash_i(squash_i),
  .full_o(full_o), .alloc_idx_o(alloc_idx_o), .sq_count_o(sq_count_o),
  .pend_q(pend_q), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
  .wr_retry_i(wr_retry_i), .wr_idx_o(wr_idx_o), .blocked_o(blocked_o),
  .free_o(free_o)
);

// File: tb/test_sq_store_queue.sv
`timescale 1ns/1ps
module test_sq_store_queue;
  localparam int DEPTH = 4;
  localparam int IDX_W = 3;
  localparam int CNT_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_i = 0, exec_i = 0, exec_pf_i = 0, commit_i = 0, squash_i = 0;
  logic wr_ready_i = 1, wr_retry_i = 0, done_i = 0;
  logic [7:0]  alloc_seq_i = 0, commit_seq_i = 0, squash_seq_i = 0, lq_free_i = 8'd7;
  logic [IDX_W-1:0] exec_idx_i = 0, done_idx_i = 0;
  logic [15:0] exec_addr_i = 0;
  logic [31:0] exec_data_i = 0;
  logic [3:0]  exec_size_i = 0;
  logic [IDX_W-1:0] alloc_idx_o, wr_idx_o;
  logic full_o, wr_valid_o, blocked_o;
  logic [15:0] wr_addr_o;
  logic [31:0] wr_data_o;
  logic [3:0]  wr_size_o;
  logic [CNT_W-1:0] free_o, sq_count_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sq_store_queue #(.DEPTH(DEPTH), .SEQ_W(8), .ADDR_W(16), .DATA_W(32),
                   .SIZE_W(4), .LQF_W(8)) i_sq_store_queue (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [7:0] s, output logic [IDX_W-1:0] idx);
    idx = alloc_idx_o;
    alloc_i = 1; alloc_seq_i = s; step(); alloc_i = 0;
  endtask

  task automatic do_exec(input logic [IDX_W-1:0] idx, input logic [15:0] a,
                         input logic [31:0] d, input logic [3:0] sz, input logic pf);
    exec_i = 1; exec_idx_i = idx; exec_addr_i = a; exec_data_i = d;
    exec_size_i = sz; exec_pf_i = pf; step(); exec_i = 0; exec_pf_i = 0;
  endtask

  task automatic do_commit(input logic [7:0] s);
    commit_i = 1; commit_seq_i = s; step(); commit_i = 0;
  endtask

  task automatic do_done(input logic [IDX_W-1:0] idx);
    done_i = 1; done_idx_i = idx; step(); done_i = 0;
  endtask

  // waits for a write, checks it, lets it be taken (wr_ready_i must be 1)
  task automatic take_write(input string req, input logic [15:0] a,
                            input logic [31:0] d, output logic [IDX_W-1:0] idx);
    int n = 0;
    while (!wr_valid_o && n < 30) begin step(); n++; end
    chk(wr_valid_o && wr_addr_o == a && wr_data_o == d, req, {wr_addr_o, wr_data_o}, {a, d});
    idx = wr_idx_o;
    step();
  endtask

  task automatic no_write(input string req, input int cycles);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      if (wr_valid_o) seen = 1;
      step();
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic t_reset();
    chk(sq_count_o == 0 && full_o == 0 && alloc_idx_o == 0, "R10 empty", sq_count_o, 0);
    chk(wr_valid_o == 0 && blocked_o == 0 && free_o == 0, "R10 outputs", {wr_valid_o, blocked_o, free_o}, 0);
  endtask

  task automatic t_fill_and_write();
    logic [IDX_W-1:0] ix [4];
    logic [IDX_W-1:0] w, keep;
    for (int k = 0; k < 4; k++) begin
      do_alloc(8'(1 + k), ix[k]);
      chk(ix[k] == IDX_W'(k), "R1 slot order", ix[k], k);
    end
    chk(full_o && sq_count_o == 4, "R1 full", sq_count_o, 4);
    chk(free_o == 0, "R9 free at full", free_o, 0);
    keep = alloc_idx_o;
    do_alloc(8'd9, w);
    chk(alloc_idx_o == keep && sq_count_o == 4, "R1 alloc when full ignored", alloc_idx_o, keep);
    for (int k = 0; k < 4; k++) do_exec(ix[k], 16'h100 + 16'(k), 32'hA0 + 32'(k), 4'd4, 0);
    do_commit(8'd4);
    for (int k = 0; k < 4; k++) begin
      take_write("R3 in-order write", 16'h100 + 16'(k), 32'hA0 + 32'(k), w);
      chk(w == ix[k], "R3 write slot", w, ix[k]);
      do_done(w);
    end
    step(); step();
    chk(sq_count_o == 0, "R7 all freed", sq_count_o, 0);
  endtask

  task automatic t_commit_bound();
    logic [IDX_W-1:0] a, b, c, w;
    do_alloc(8'd10, a); do_alloc(8'd11, b); do_alloc(8'd12, c);
    do_exec(a, 16'h200, 32'h1, 4'd4, 0);
    do_exec(b, 16'h204, 32'h2, 4'd4, 0);
    do_exec(c, 16'h208, 32'h3, 4'd4, 0);
    do_commit(8'd11);
    take_write("R2 first committed", 16'h200, 32'h1, w); do_done(w);
    take_write("R2 second committed", 16'h204, 32'h2, w); do_done(w);
    no_write("R2 uncommitted store held back", 10);
    chk(sq_count_o == 1, "R2 one store left", sq_count_o, 1);
    do_commit(8'd12);
    take_write("R2 later commit", 16'h208, 32'h3, w); do_done(w);
    step(); step();
    chk(sq_count_o == 0, "R2 drained", sq_count_o, 0);
  endtask

  task automatic t_skips();
    logic [IDX_W-1:0] a, b, c, w;
    do_alloc(8'd20, a); do_alloc(8'd21, b); do_alloc(8'd22, c);
    do_exec(a, 16'h300, 32'h11, 4'd0, 0);
    do_exec(b, 16'h304, 32'h22, 4'd8, 1);
    do_exec(c, 16'h308, 32'h33, 4'd2, 0);
    do_commit(8'd22);
    take_write("R4 R5 only real store written", 16'h308, 32'h33, w);
    chk(w == c, "R4 written slot", w, c);
    step(); step();
    chk(sq_count_o == 1, "R4 R5 skipped stores freed", sq_count_o, 1);
    do_done(w); step();
    chk(sq_count_o == 0, "R7 head freed", sq_count_o, 0);
  endtask

  task automatic t_refusal();
    logic [IDX_W-1:0] a;
    int n = 0;
    wr_ready_i = 0;
    do_alloc(8'd30, a);
    do_exec(a, 16'h400, 32'hBEEF, 4'd4, 0);
    do_commit(8'd30);
    while (!wr_valid_o && n < 30) begin step(); n++; end
    chk(wr_valid_o && wr_addr_o == 16'h400, "R6 first request", wr_addr_o, 16'h400);
    step();
    chk(!wr_valid_o && blocked_o, "R6 refused -> blocked", {wr_valid_o, blocked_o}, 1);
    no_write("R6 silent until retry", 4);
    chk(blocked_o, "R6 still blocked", blocked_o, 1);
    wr_ready_i = 1; wr_retry_i = 1; step(); wr_retry_i = 0;
    chk(wr_valid_o && wr_addr_o == 16'h400 && wr_data_o == 32'hBEEF && wr_idx_o == a,
        "R6 same request after retry", wr_addr_o, 16'h400);
    step();
    chk(!blocked_o && !wr_valid_o, "R6 taken", {blocked_o, wr_valid_o}, 0);
    do_done(a); step();
    chk(sq_count_o == 0, "R6 freed", sq_count_o, 0);
  endtask

  task automatic t_out_of_order_done();
    logic [IDX_W-1:0] a, b, w0, w1;
    do_alloc(8'd40, a); do_alloc(8'd41, b);
    do_exec(a, 16'h500, 32'h5, 4'd4, 0);
    do_exec(b, 16'h504, 32'h6, 4'd4, 0);
    do_commit(8'd41);
    take_write("R7 write a", 16'h500, 32'h5, w0);
    take_write("R7 write b", 16'h504, 32'h6, w1);
    do_done(w1); step(); step(); step();
    chk(sq_count_o == 2, "R7 younger done, nothing freed", sq_count_o, 2);
    do_done(w0);
    chk(sq_count_o == 2, "R7 not yet freed", sq_count_o, 2);
    step();
    chk(sq_count_o == 0, "R7 run freed at once", sq_count_o, 0);
  endtask

  task automatic t_squash();
    logic [IDX_W-1:0] a, b, c, d, w;
    do_alloc(8'd50, a); do_alloc(8'd51, b); do_alloc(8'd52, c); do_alloc(8'd53, d);
    do_commit(8'd51);
    squash_i = 1; squash_seq_i = 8'd50; step(); squash_i = 0;
    chk(sq_count_o == 2, "R8 two removed", sq_count_o, 2);
    chk(alloc_idx_o == c, "R8 tail restored", alloc_idx_o, c);
    squash_i = 1; squash_seq_i = 8'd51; alloc_i = 1; alloc_seq_i = 8'd60;
    commit_i = 1; commit_seq_i = 8'd60; step();
    squash_i = 0; alloc_i = 0; commit_i = 0;
    chk(sq_count_o == 2 && alloc_idx_o == c, "R8 alloc ignored during squash", sq_count_o, 2);
    do_exec(a, 16'h600, 32'h7, 4'd4, 0);
    do_exec(b, 16'h604, 32'h8, 4'd4, 0);
    take_write("R8 kept store a", 16'h600, 32'h7, w); do_done(w);
    take_write("R8 kept store b", 16'h604, 32'h8, w); do_done(w);
    no_write("R8 removed stores not written", 8);
    chk(sq_count_o == 0, "R8 empty", sq_count_o, 0);
  endtask

  task automatic t_free();
    logic [IDX_W-1:0] a;
    lq_free_i = 8'd1; step(); step();
    chk(free_o == 1, "R9 load queue limits", free_o, 1);
    lq_free_i = 8'd7;
    do_alloc(8'd70, a);
    chk(free_o == 3, "R9 store queue limits", free_o, 3);
    squash_i = 1; squash_seq_i = 8'd69; step(); squash_i = 0;
    chk(free_o == 4 && sq_count_o == 0, "R9 after squash", free_o, 4);
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    t_reset();
    step();
    chk(free_o == 4, "R9 empty queue", free_o, 4);
    t_fill_and_write();
    t_commit_bound();
    t_skips();
    t_refusal();
    t_out_of_order_done();
    t_squash();
    t_free();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule